// File: doc/BRIEF.md
# Serial Latch Loader

The block takes a three-wire serial programming stream and sorts each received word into one of four parameter holding registers. The three wires are a serial clock, a serial data line and a load strobe. All three arrive asynchronous to the system clock. Each one passes through its own multi-flop synchronizer, and edges are found on the synchronized copies. Every rising edge of the serial clock pushes one data bit into a 21-bit shift register. The most significant bit arrives first, so the register always holds the last 21 bits received.

A rising edge on the load strobe commits the shift register contents to a holding register. The two lowest bits of the word itself choose which one. There is no separate address phase.

The holding registers are:
- a 14-bit reference divide value;
- a feedback divide value, split into a 5-bit low field and a 13-bit high field;
- a 19-bit function word;
- a 19-bit initialization word. Committing the initialization word also overwrites the function word with the same payload.

A one-cycle strobe tells downstream logic which register was just written.

Top module: `serial_latch_loader`

## Requirements
- R1: While reset is asserted and after its release, all four holding registers read zero and no write strobe is raised.
- R2: Each rising edge of the serial clock shifts the data line into the 21-bit shift register, most significant bit first. When more than 21 bits are sent, only the last 21 are kept.
- R3: A transfer happens only on the rising edge of the load strobe. Holding the strobe high while shifting, or lowering it, changes no holding register.
- R4: Control code 00 in bits [1:0] loads bits [15:2] of the word into the 14-bit reference divide output.
- R5: Control code 01 loads bits [6:2] into the low feedback field and bits [19:7] into the high feedback field.
- R6: Control code 10 loads bits [20:2] into the 19-bit function output.
- R7: Control code 11 loads bits [20:2] into the initialization output and into the function output.
- R8: Holding registers that the control code does not select keep their previous contents.
- R9: Each transfer raises exactly one write strobe bit for exactly one system clock cycle. The bit index is the control code: bit 0 for code 00, bit 1 for 01, bit 2 for 10, bit 3 for 11.
- R10: Serial inputs are sampled through two-flop synchronizers. A bit is captured correctly when the data line settles at least three system clocks before a serial clock rise, and each serial clock level is held for at least three system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdata_i | input | 1 | Serial data, MSB first, asynchronous |
| load_i | input | 1 | Load strobe; rising edge commits the word |
| r_val_o | output | 14 | Reference divide value |
| n_a_o | output | 5 | Feedback divide low field |
| n_b_o | output | 13 | Feedback divide high field |
| func_o | output | 19 | Function word payload |
| init_o | output | 19 | Initialization word payload |
| wr_strb_o | output | 4 | One-cycle write strobe, one bit per destination |

## Verification
The hardest case to reach is a change to the shift register while the load strobe is already high.

To create it, the bench commits one word, keeps the strobe high, and clocks a completely different word in. It then lowers the strobe and checks that no register moved and that only the single strobe pulse from the original rise was seen.

The bench also sends a stream longer than the register, with leading garbage bits, to show that only the trailing 21 bits reach a holding register. Random words with random control codes cover the decode. Each transfer is followed by a check of every register, so a stray write to an unselected register is detected.

// File: rtl/sll_pkg.sv
package sll_pkg;
   localparam int unsigned SEL_W   = 2;
   localparam int unsigned NUM_DST = 4;

   typedef enum logic [SEL_W-1:0] {
      DST_RCNT = 2'b00,
      DST_NCNT = 2'b01,
      DST_FUNC = 2'b10,
      DST_INIT = 2'b11
   } dst_e;
endpackage

// File: rtl/sll_sync.sv
module sll_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic async_i,
   output logic level_o,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("sll_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         chain_q <= '0;
         last_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         last_q  <= chain_q[STAGES-1];
      end
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/sll_shift.sv
module sll_shift #(
   parameter int unsigned WORD_W = 21
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              shift_en_i,
   input  logic              bit_i,
   output logic [WORD_W-1:0] word_o
);
   if (WORD_W < 3) begin : g_bad_width
      $error("sll_shift: WORD_W must be at least 3");
   end

   logic [WORD_W-1:0] sr_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         sr_q <= '0;
      end else if (shift_en_i) begin
         sr_q <= {sr_q[WORD_W-2:0], bit_i};
      end
   end

   assign word_o = sr_q;
endmodule

// File: rtl/sll_bank.sv
module sll_bank
   import sll_pkg::*;
#(
   parameter int unsigned WORD_W       = 21,
   parameter int unsigned R_W          = 14,
   parameter int unsigned A_W          = 5,
   parameter int unsigned B_W          = 13,
   parameter bit          INIT_TO_FUNC = 1'b1
) (
   input  logic                   clk_i,
   input  logic                   rst_i,
   input  logic                   load_en_i,
   input  logic [WORD_W-1:0]      word_i,
   output logic [R_W-1:0]         r_o,
   output logic [A_W-1:0]         a_o,
   output logic [B_W-1:0]         b_o,
   output logic [WORD_W-SEL_W-1:0] func_o,
   output logic [WORD_W-SEL_W-1:0] init_o,
   output logic [NUM_DST-1:0]     strb_o
);
   localparam int unsigned PAY_W = WORD_W - SEL_W;
   localparam int unsigned A_LSB = SEL_W;
   localparam int unsigned B_LSB = A_LSB + A_W;

   if (R_W > PAY_W) begin : g_bad_r
      $error("sll_bank: R_W exceeds payload width");
   end
   if (A_W + B_W > PAY_W) begin : g_bad_n
      $error("sll_bank: A_W + B_W exceeds payload width");
   end

   dst_e             code;
   logic [PAY_W-1:0] payload;
   logic             we_r, we_n, we_f, we_i, we_func_any;

   assign code    = dst_e'(word_i[SEL_W-1:0]);
   assign payload = word_i[WORD_W-1:SEL_W];

   assign we_r = load_en_i && (code == DST_RCNT);
   assign we_n = load_en_i && (code == DST_NCNT);
   assign we_f = load_en_i && (code == DST_FUNC);
   assign we_i = load_en_i && (code == DST_INIT);

   if (INIT_TO_FUNC) begin : g_init_copies
      assign we_func_any = we_f | we_i;
   end else begin : g_init_separate
      assign we_func_any = we_f;
   end

   logic [R_W-1:0]     r_q;
   logic [A_W-1:0]     a_q;
   logic [B_W-1:0]     b_q;
   logic [PAY_W-1:0]   f_q, i_q;
   logic [NUM_DST-1:0] strb_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         r_q    <= '0;
         a_q    <= '0;
         b_q    <= '0;
         f_q    <= '0;
         i_q    <= '0;
         strb_q <= '0;
      end else begin
         if (we_r)        r_q <= payload[R_W-1:0];
         if (we_n) begin
            a_q <= word_i[A_LSB +: A_W];
            b_q <= word_i[B_LSB +: B_W];
         end
         if (we_func_any) f_q <= payload;
         if (we_i)        i_q <= payload;
         strb_q <= load_en_i ? (NUM_DST'(1) << word_i[SEL_W-1:0]) : '0;
      end
   end

   assign r_o    = r_q;
   assign a_o    = a_q;
   assign b_o    = b_q;
   assign func_o = f_q;
   assign init_o = i_q;
   assign strb_o = strb_q;
endmodule

// File: rtl/serial_latch_loader.sv
module serial_latch_loader
   import sll_pkg::*;
#(
   parameter int unsigned WORD_W       = 21,
   parameter int unsigned R_W          = 14,
   parameter int unsigned A_W          = 5,
   parameter int unsigned B_W          = 13,
   parameter int unsigned SYNC_STAGES  = 2,
   parameter bit          INIT_TO_FUNC = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_i,
   input  logic                    sclk_i,
   input  logic                    sdata_i,
   input  logic                    load_i,
   output logic [R_W-1:0]          r_val_o,
   output logic [A_W-1:0]          n_a_o,
   output logic [B_W-1:0]          n_b_o,
   output logic [WORD_W-SEL_W-1:0] func_o,
   output logic [WORD_W-SEL_W-1:0] init_o,
   output logic [NUM_DST-1:0]      wr_strb_o
);
   localparam int unsigned N_IN   = 3;
   localparam int unsigned IX_CLK = 0;
   localparam int unsigned IX_DAT = 1;
   localparam int unsigned IX_LD  = 2;

   logic [N_IN-1:0] raw_in, lvl, rise;
   logic [WORD_W-1:0] sr_word;
   logic load_rise;

   assign raw_in = {load_i, sdata_i, sclk_i};

   for (genvar g = 0; g < N_IN; g++) begin : g_sync
      sll_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i  (clk_i),
         .rst_i  (rst_i),
         .async_i(raw_in[g]),
         .level_o(lvl[g]),
         .rise_o (rise[g])
      );
   end

   assign load_rise = rise[IX_LD];

   sll_shift #(.WORD_W(WORD_W)) u_shift (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .shift_en_i(rise[IX_CLK]),
      .bit_i     (lvl[IX_DAT]),
      .word_o    (sr_word)
   );

   sll_bank #(
      .WORD_W      (WORD_W),
      .R_W         (R_W),
      .A_W         (A_W),
      .B_W         (B_W),
      .INIT_TO_FUNC(INIT_TO_FUNC)
   ) u_bank (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .load_en_i(load_rise),
      .word_i   (sr_word),
      .r_o      (r_val_o),
      .a_o      (n_a_o),
      .b_o      (n_b_o),
      .func_o   (func_o),
      .init_o   (init_o),
      .strb_o   (wr_strb_o)
   );

   logic unused_lvl;
   assign unused_lvl = lvl[IX_CLK] ^ lvl[IX_LD] ^ rise[IX_DAT];
endmodule

// File: rtl/serial_latch_loader_chk.sv
module serial_latch_loader_chk #(
   parameter int unsigned R_W   = 14,
   parameter int unsigned A_W   = 5,
   parameter int unsigned B_W   = 13,
   parameter int unsigned PAY_W = 19
) (
   input logic             clk_i,
   input logic             rst_i,
   input logic             load_rise,
   input logic [R_W-1:0]   r_val_o,
   input logic [A_W-1:0]   n_a_o,
   input logic [B_W-1:0]   n_b_o,
   input logic [PAY_W-1:0] func_o,
   input logic [PAY_W-1:0] init_o,
   input logic [3:0]       wr_strb_o
);
   p_strobe_onehot_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(wr_strb_o));

   p_strobe_single_r9: assert property (@(posedge clk_i) disable iff (rst_i)
      (|wr_strb_o) |=> (wr_strb_o == 4'b0000));

   p_strobe_cause_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      (|wr_strb_o) |-> $past(load_rise));

   p_hold_r_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !wr_strb_o[0] |-> $stable(r_val_o));

   p_hold_n_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !wr_strb_o[1] |-> ($stable(n_a_o) && $stable(n_b_o)));

   p_hold_func_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !(wr_strb_o[2] || wr_strb_o[3]) |-> $stable(func_o));

   p_hold_init_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      !wr_strb_o[3] |-> $stable(init_o));

   p_init_copy_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      wr_strb_o[3] |-> (func_o == init_o));
endmodule

bind serial_latch_loader serial_latch_loader_chk #(
   .R_W  (R_W),
   .A_W  (A_W),
   .B_W  (B_W),
   .PAY_W(WORD_W - 2)
) u_chk (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .load_rise(load_rise),
   .r_val_o  (r_val_o),
   .n_a_o    (n_a_o),
   .n_b_o    (n_b_o),
   .func_o   (func_o),
   .init_o   (init_o),
   .wr_strb_o(wr_strb_o)
);

// File: tb/serial_latch_loader_bench.sv
`timescale 1ns/1ps
module serial_latch_loader_bench;
   logic clk = 1'b0;
   logic rst, sclk, sdata, load;
   logic [13:0] r_val;
   logic [4:0]  n_a;
   logic [12:0] n_b;
   logic [18:0] func_w, init_w;
   logic [3:0]  strb;

   always #2 clk = ~clk;

   serial_latch_loader u_serial_latch_loader (
      .clk_i(clk), .rst_i(rst), .sclk_i(sclk), .sdata_i(sdata), .load_i(load),
      .r_val_o(r_val), .n_a_o(n_a), .n_b_o(n_b), .func_o(func_w),
      .init_o(init_w), .wr_strb_o(strb)
   );

   int total = 0;
   int fails = 0;
   int stb_cnt [4];
   logic done = 1'b0;

   logic [13:0] e_r;
   logic [4:0]  e_a;
   logic [12:0] e_b;
   logic [18:0] e_f, e_i;

   always @(negedge clk) begin
      for (int i = 0; i < 4; i++) if (strb[i] === 1'b1) stb_cnt[i]++;
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
   endtask

   task automatic send_bits(input logic [31:0] w, input int n);
      for (int k = n - 1; k >= 0; k--) begin
         sdata = w[k];
         wait_clk(3);
         sclk = 1'b1;
         wait_clk(3);
         sclk = 1'b0;
         wait_clk(3);
      end
   endtask

   task automatic clear_cnt();
      @(negedge clk);
      for (int i = 0; i < 4; i++) stb_cnt[i] = 0;
   endtask

   // Expected model: R4 R5 R6 R7, others hold (R8)
   task automatic model(input logic [20:0] w);
      case (w[1:0])
         2'b00: e_r = w[15:2];
         2'b01: begin e_a = w[6:2]; e_b = w[19:7]; end
         2'b10: e_f = w[20:2];
         default: begin e_i = w[20:2]; e_f = w[20:2]; end
      endcase
   endtask

   task automatic verify(input string tag, input int code);
      @(negedge clk);
      chk(r_val == e_r, {tag, " R4/R8 ref"}, 32'(r_val), 32'(e_r));
      chk(n_a == e_a && n_b == e_b, {tag, " R5/R8 fb"}, {n_b, n_a}, {e_b, e_a});
      chk(func_w == e_f, {tag, " R6/R7 func"}, 32'(func_w), 32'(e_f));
      chk(init_w == e_i, {tag, " R7/R8 init"}, 32'(init_w), 32'(e_i));
      for (int i = 0; i < 4; i++)
         chk(stb_cnt[i] == ((i == code) ? 1 : 0), {tag, " R9 strobe"}, 32'(stb_cnt[i]), (i == code) ? 1 : 0);
   endtask

   task automatic load_word(input logic [20:0] w, input string tag);
      send_bits(32'(w), 21);
      clear_cnt();
      load = 1'b1;
      wait_clk(6);
      load = 1'b0;
      wait_clk(4);
      model(w);
      verify(tag, int'(w[1:0]));
   endtask

   initial begin
      #(4ns * 200000);
      if (!done) begin
         fails++;
         total++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic [20:0] w1, w2;
      logic [31:0] rnd;
      void'($urandom(32'd20240611));
      rst = 1'b1; sclk = 1'b0; sdata = 1'b0; load = 1'b0;
      e_r = '0; e_a = '0; e_b = '0; e_f = '0; e_i = '0;
      for (int i = 0; i < 4; i++) stb_cnt[i] = 0;
      wait_clk(5);
      @(negedge clk);
      chk(r_val == 0 && n_a == 0 && n_b == 0 && func_w == 0 && init_w == 0, "R1 reset latches", 32'(func_w | init_w), 0);
      chk(strb == 0, "R1 reset strobe", 32'(strb), 0);
      rst = 1'b0;
      wait_clk(4);
      chk(strb == 0 && r_val == 0, "R1 after release", 32'(strb), 0);

      // directed: each code once (R4..R7, R10 timing margins)
      load_word({5'h0, 14'h2A5B, 2'b00}, "dir");
      load_word({1'b0, 13'h1ABC, 5'h15, 2'b01}, "dir");
      load_word({19'h5A5A5, 2'b10}, "dir");
      load_word({19'h3C3C3, 2'b11}, "dir");
      load_word({19'h7FFFF, 2'b10}, "dir");

      // R2: 25-bit stream with 4 leading garbage bits
      w1 = {5'h1F, 14'h1234, 2'b00};
      send_bits({7'h0, 4'hF, w1}, 25);
      clear_cnt();
      load = 1'b1; wait_clk(6); load = 1'b0; wait_clk(4);
      model(w1);
      verify("R2 overlong", 0);

      // R3: shifting while load held high and the falling edge transfer nothing
      w1 = {1'b1, 13'h0F0F, 5'h0A, 2'b01};
      w2 = {1'b0, 13'h10F0, 5'h15, 2'b01};
      send_bits(32'(w1), 21);
      clear_cnt();
      load = 1'b1;
      wait_clk(6);
      send_bits(32'(w2), 21);
      load = 1'b0;
      wait_clk(6);
      model(w1);
      verify("R3 held", 1);
      clear_cnt();
      load = 1'b1; wait_clk(6); load = 1'b0; wait_clk(4);
      model(w2);
      verify("R3 repulse", 1);

      // random words
      for (int n = 0; n < 40; n++) begin
         rnd = $urandom;
         load_word(rnd[20:0], "rand");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule